// File: doc/BRIEF.md
# Residual Uniform Quantizer and Dequantizer

This block sits between the prediction stage and the residual mapper of a near-lossless spectral image compressor. It takes one signed prediction residual at a time and turns it into a quantization index. The index is the residual's magnitude, plus half the step rounded down, divided by the step, with the residual's sign kept. From that index the block also forms the dequantized residual, the index times the step. The predictor uses it to rebuild the sample it will later predict from and to update its weights.

The step is an unsigned 9-bit value from 1 to 511. Outside logic picks it once per spectral line and writes it through a load strobe. The block holds that step for every sample that follows, until the next load. A step of 1 makes the path lossless. The division is a restoring shift-subtract divider that takes a fixed number of cycles, so the block accepts a new residual only while it is idle.

The block runs as a two-state machine. In `ST_IDLE` it waits for a residual. The transition *accept* (`in_valid` while idle) captures the sign, the step and the rounded magnitude and starts the divider, and the machine enters `ST_DIVIDE`. The transition *finish* (the divider's done pulse) registers the index and the dequantized residual, pulses `out_done` and returns the machine to `ST_IDLE`. The divider has its own pair of states, `DV_IDLE` and `DV_RUN`. It leaves `DV_RUN` after one iteration per numerator bit.

Top module: `rq_quantizer`

## Requirements
- R1: While reset is held and right after it, `busy`, `out_done`, `out_index` and `out_recon` are 0 and `step_now` is 1.
- R2: For a residual r and a held step Q, `out_index` equals sign(r) × floor((|r| + floor(Q/2)) / Q), two's complement.
- R3: `out_recon` equals `out_index` × Q, signed and one bit wider than the residual, in the same cycle as `out_index`.
- R4: With Q = 1, both `out_index` and `out_recon` equal the input residual for every value, including the most negative.
- R5: A residual of 0 gives index 0 and dequantized residual 0 for any Q.
- R6: A residual accepted at clock edge k (`in_valid` high while `busy` is low) sets `busy` from edge k to edge k+RES_W+2. `out_done` is high for the single cycle after edge k+RES_W+2, with `busy` low in that cycle. This is 18 edges with the default width.
- R7: `in_valid` while `busy` is high is ignored: it causes no extra `out_done` and does not alter the result in flight.
- R8: A load strobe with a nonzero `step_value` while idle updates `step_now` at that edge. A residual accepted in the same cycle still uses the previous step.
- R9: A load strobe during a division does not change the step of that division. It is held and applied at the edge that ends the division. The latest such load wins, and `step_now` stays stable while busy.
- R10: A load strobe carrying step value 0 is ignored, whether idle or busy, and `step_now` is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_load | input | 1 | Strobe to write a new quantization step |
| step_value | input | 9 | Step to write, 1 to 511; 0 is ignored |
| in_valid | input | 1 | Residual present; taken only while not busy |
| in_residual | input | 16 | Signed prediction residual |
| busy | output | 1 | High while a division is in progress |
| out_done | output | 1 | One-cycle pulse when a result is ready |
| out_index | output | 16 | Signed quantization index |
| out_recon | output | 17 | Signed dequantized residual, index × step |
| step_now | output | 9 | Step currently held for the line |

## Verification
Each accepted residual yields its result exactly RES_W+2 edges after the accepting edge. The reference model in the bench therefore records a due cycle with every expected index and dequantized value. On each falling edge the bench compares `out_done` against whether a result is due in that cycle, and compares the values only then. The same model tracks when `busy` must rise and fall and when a held step takes effect, so `busy` and `step_now` are compared on every cycle, not only at result time. Pokes on `in_valid` during a division and step loads that land mid-division are placed at known offsets inside the busy window, so their effect shows up at a predictable cycle.

// File: rtl/rq_pkg.sv
package rq_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_DIVIDE
    } rq_state_e;

    typedef enum logic {
        DV_IDLE,
        DV_RUN
    } rq_div_state_e;

endpackage

// File: rtl/rq_front.sv
module rq_front #(
    parameter int RES_W  = 16,
    parameter int STEP_W = 9,
    parameter int NUM_W  = RES_W + 1
) (
    input  logic signed [RES_W-1:0]  residual,
    input  logic        [STEP_W-1:0] step,
    output logic        [NUM_W-1:0]  num,
    output logic                     neg
);

    logic [RES_W-1:0] mag;

    always_comb begin
        neg = residual[RES_W-1];
        mag = neg ? (~residual + RES_W'(1)) : residual;
        num = NUM_W'(mag) + NUM_W'(step >> 1);
    end

endmodule

// File: rtl/rq_divider.sv
module rq_divider
    import rq_pkg::*;
#(
    parameter int NUM_W = 17,
    parameter int DEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    rq_div_state_e      st_q, st_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [DEN_W-1:0]   rem_q, den_q, rem_n;
    logic [NUM_W-1:0]   quo_q;
    logic [DEN_W:0]     wide;
    logic               fits;
    logic               done_q;
    logic               last_iter;

    assign last_iter = (cnt_q == CNT_W'(1));

    always_comb begin
        wide  = {rem_q, quo_q[NUM_W-1]};
        fits  = (wide >= {1'b0, den_q});
        rem_n = fits ? DEN_W'(wide - {1'b0, den_q}) : DEN_W'(wide);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DV_IDLE: if (start) st_d = DV_RUN;
            DV_RUN:  if (last_iter) st_d = DV_IDLE;
            default: st_d = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DV_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rem_q  <= '0;
            den_q  <= DEN_W'(1);
            quo_q  <= '0;
            done_q <= 1'b0;
        end else begin
            unique case (st_q)
                DV_IDLE: begin
                    done_q <= 1'b0;
                    if (start) begin
                        rem_q <= '0;
                        quo_q <= num;
                        den_q <= den;
                        cnt_q <= CNT_W'(NUM_W);
                    end
                end
                DV_RUN: begin
                    rem_q  <= rem_n;
                    quo_q  <= {quo_q[NUM_W-2:0], fits};
                    cnt_q  <= cnt_q - CNT_W'(1);
                    done_q <= last_iter;
                end
                default: done_q <= 1'b0;
            endcase
        end
    end

    assign busy = (st_q == DV_RUN);
    assign done = done_q;
    assign quot = quo_q;

endmodule

// File: rtl/rq_step_hold.sv
module rq_step_hold #(
    parameter int STEP_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              finish,
    input  logic              load,
    input  logic [STEP_W-1:0] load_val,
    output logic [STEP_W-1:0] step
);

    logic              load_ok;
    logic              pend_q;
    logic [STEP_W-1:0] pend_val_q;
    logic [STEP_W-1:0] step_q;

    assign load_ok = load && (load_val != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q     <= STEP_W'(1);
            pend_q     <= 1'b0;
            pend_val_q <= STEP_W'(1);
        end else if (idle) begin
            pend_q <= 1'b0;
            if (load_ok) step_q <= load_val;
        end else if (finish) begin
            pend_q <= 1'b0;
            if (load_ok)     step_q <= load_val;
            else if (pend_q) step_q <= pend_val_q;
        end else if (load_ok) begin
            pend_q     <= 1'b1;
            pend_val_q <= load_val;
        end
    end

    assign step = step_q;

endmodule

// File: rtl/rq_quantizer.sv
module rq_quantizer
    import rq_pkg::*;
#(
    parameter int RES_W  = 16,
    parameter int STEP_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_load,
    input  logic        [STEP_W-1:0] step_value,
    input  logic                     in_valid,
    input  logic signed [RES_W-1:0]  in_residual,
    output logic                     busy,
    output logic                     out_done,
    output logic signed [RES_W-1:0]  out_index,
    output logic signed [RES_W:0]    out_recon,
    output logic        [STEP_W-1:0] step_now
);

    localparam int NUM_W  = RES_W + 1;
    localparam int PROD_W = NUM_W + STEP_W + 2;

    rq_state_e           state_q, state_d;
    logic                accept;
    logic                div_busy, div_done;
    logic [NUM_W-1:0]    num_c, quot;
    logic                neg_c, neg_q;
    logic [STEP_W-1:0]   step_q, op_step_q;
    logic                is_idle;
    logic signed [NUM_W:0]  mag_s, idx_s;
    logic signed [PROD_W-1:0] prod_s;

    assign is_idle = (state_q == ST_IDLE);
    assign accept  = is_idle && in_valid && !div_busy;

    rq_front #(
        .RES_W  (RES_W),
        .STEP_W (STEP_W),
        .NUM_W  (NUM_W)
    ) u_front (
        .residual (in_residual),
        .step     (step_q),
        .num      (num_c),
        .neg      (neg_c)
    );

    rq_divider #(
        .NUM_W (NUM_W),
        .DEN_W (STEP_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .num   (num_c),
        .den   (step_q),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (quot)
    );

    rq_step_hold #(
        .STEP_W (STEP_W)
    ) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (is_idle),
        .finish   (div_done),
        .load     (step_load),
        .load_val (step_value),
        .step     (step_q)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)   state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        mag_s  = $signed({1'b0, quot});
        idx_s  = neg_q ? -mag_s : mag_s;
        prod_s = idx_s * $signed({1'b0, op_step_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q     <= 1'b0;
            op_step_q <= STEP_W'(1);
            out_done  <= 1'b0;
            out_index <= '0;
            out_recon <= '0;
        end else begin
            out_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        neg_q     <= neg_c;
                        op_step_q <= step_q;
                    end
                end
                ST_DIVIDE: begin
                    if (div_done) begin
                        out_done  <= 1'b1;
                        out_index <= RES_W'(idx_s);
                        out_recon <= (RES_W+1)'(prod_s);
                    end
                end
                default: out_done <= 1'b0;
            endcase
        end
    end

    assign busy     = (state_q == ST_DIVIDE);
    assign step_now = step_q;

endmodule

// File: rtl/rq_quantizer_chk.sv
module rq_quantizer_chk #(
    parameter int RES_W  = 16,
    parameter int STEP_W = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     busy,
    input logic                     out_done,
    input logic signed [RES_W-1:0]  out_index,
    input logic signed [RES_W:0]    out_recon,
    input logic        [STEP_W-1:0] step_now
);

    // R6: result strobe lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);

    // R6: an idle-time request makes the block busy on the next cycle
    a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid) |=> busy);

    // R6: the result appears in an idle cycle that follows a busy one
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (!busy && $past(busy)));

    // R9: the held step does not move in the middle of a division
    a_r9_step_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(step_now));

    // R10: a zero step never reaches the held register
    a_r10_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        step_now != '0);

    // R3: a zero index dequantizes to zero
    a_r3_zero_recon: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_index == '0) |-> (out_recon == '0));

    // R2: index and dequantized residual carry the same sign
    a_r2_sign_match: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_index != '0) |-> (out_index[RES_W-1] == out_recon[RES_W]));

endmodule

bind rq_quantizer rq_quantizer_chk #(
    .RES_W  (RES_W),
    .STEP_W (STEP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_done  (out_done),
    .out_index (out_index),
    .out_recon (out_recon),
    .step_now  (step_now)
);

// File: tb/rq_quantizer_tb.sv
module rq_quantizer_tb;

    localparam int RES_W  = 16;
    localparam int STEP_W = 9;
    localparam int LAT    = RES_W + 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     step_load = 1'b0;
    logic        [STEP_W-1:0] step_value = '0;
    logic                     in_valid = 1'b0;
    logic signed [RES_W-1:0]  in_residual = '0;
    logic                     busy;
    logic                     out_done;
    logic signed [RES_W-1:0]  out_index;
    logic signed [RES_W:0]    out_recon;
    logic        [STEP_W-1:0] step_now;

    always #10 clk = ~clk;

    rq_quantizer #(.RES_W(RES_W), .STEP_W(STEP_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_load   (step_load),
        .step_value  (step_value),
        .in_valid    (in_valid),
        .in_residual (in_residual),
        .busy        (busy),
        .out_done    (out_done),
        .out_index   (out_index),
        .out_recon   (out_recon),
        .step_now    (step_now)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    ended = 1'b0;
    string cur_tag = "R2";

    // behavioural reference state
    int    cyc = 0;
    int    busy_until = -1;
    int    m_step = 1;
    bit    pend = 1'b0;
    int    pend_v = 1;
    int    exp_due[$];
    int    exp_idx[$];
    int    exp_rec[$];
    string exp_tag[$];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cyc - 1 >= busy_until) begin
                if (in_valid) begin
                    int r, mag, idx;
                    r   = int'(in_residual);
                    mag = (r < 0) ? -r : r;
                    idx = (mag + m_step / 2) / m_step;
                    if (r < 0) idx = -idx;
                    exp_due.push_back(cyc + LAT);
                    exp_idx.push_back(idx);
                    exp_rec.push_back(idx * m_step);
                    exp_tag.push_back(cur_tag);
                    busy_until = cyc + LAT;
                end
                if (step_load && step_value != 0) m_step = int'(step_value);
                pend = 1'b0;
            end else begin
                if (step_load && step_value != 0) begin
                    pend   = 1'b1;
                    pend_v = int'(step_value);
                end
                if (cyc == busy_until) begin
                    if (pend) m_step = pend_v;
                    pend = 1'b0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            bit due;
            due = (exp_due.size() > 0) && (exp_due[0] == cyc);
            chk("R6", "busy", int'(busy), int'(cyc < busy_until));
            chk("R6 R7", "out_done", int'(out_done), int'(due));
            chk("R8 R9 R10", "step_now", int'(step_now), m_step);
            if (due) begin
                chk(exp_tag[0], "out_index", int'(out_index), exp_idx[0]);
                chk("R3", "out_recon", int'(out_recon), exp_rec[0]);
                void'(exp_due.pop_front());
                void'(exp_idx.pop_front());
                void'(exp_rec.pop_front());
                void'(exp_tag.pop_front());
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic send(input int r, input string t);
        wait_idle();
        cur_tag     = t;
        in_valid    = 1'b1;
        in_residual = RES_W'(r);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic load_step(input int q);
        wait_idle();
        step_load  = 1'b1;
        step_value = STEP_W'(q);
        @(negedge clk);
        step_load = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "out_done", int'(out_done), 0);
        chk("R1", "out_index", int'(out_index), 0);
        chk("R1", "out_recon", int'(out_recon), 0);
        chk("R1", "step_now", int'(step_now), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: step 1 after reset is lossless
        send(0, "R4");
        send(5, "R4");
        send(-7, "R4");
        send(32767, "R4");
        send(-32768, "R4");

        // R2: rounding boundaries
        load_step(4);
        send(1, "R2");
        send(2, "R2");
        send(-2, "R2");
        send(-6, "R2");
        load_step(511);
        send(255, "R2");
        send(256, "R2");
        send(-32768, "R2");
        send(32767, "R2");
        load_step(3);
        send(-4, "R2");
        send(4, "R2");

        // R5: zero residual
        send(0, "R5");
        load_step(2);
        send(0, "R5");

        // R7: requests during a division are dropped
        send(1000, "R7");
        repeat (2) @(negedge clk);
        in_residual = RES_W'(-9999);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;

        // R8: load and request in the same idle cycle
        wait_idle();
        cur_tag     = "R8";
        step_load   = 1'b1;
        step_value  = STEP_W'(7);
        in_valid    = 1'b1;
        in_residual = RES_W'(100);
        @(negedge clk);
        step_load = 1'b0;
        in_valid  = 1'b0;
        send(100, "R8");

        // R9: loads during a division wait for its end, last one wins
        send(-500, "R9");
        @(negedge clk);
        step_load = 1'b1; step_value = STEP_W'(5);
        @(negedge clk);
        step_load = 1'b0;
        @(negedge clk);
        step_load = 1'b1; step_value = STEP_W'(9);
        @(negedge clk);
        step_load = 1'b0;
        send(-500, "R9");

        // R10: zero step ignored while busy and while idle
        send(77, "R10");
        @(negedge clk);
        step_load = 1'b1; step_value = '0;
        @(negedge clk);
        step_load = 1'b0;
        load_step(0);
        send(77, "R10");

        // R2: mixed traffic
        for (int i = 0; i < 40; i++) begin
            if (i % 8 == 0) load_step(int'($urandom_range(1, 511)));
            send(int'($urandom_range(0, 65535)) - 32768, "R2");
        end

        wait_idle();
        repeat (25) @(negedge clk);
        finish_up();
    end

endmodule